// File: doc/BRIEF.md
# Closed Caption Line Data Extractor

This block is the digital back end of a slicer for data sent in the vertical blanking interval. It runs on a 4 MHz clock. Its inputs are the already-sliced one-bit video stream, the composite sync (active low) and a horizontal pulse. It finds vertical sync by measuring how long the sync input stays low. It counts lines from that point, works out which of the two fields is in progress, and drives a clamp-enable output that stays off through the top lines of the blanking interval.

Software picks one line number and one field. On that line the block looks for a clock run-in followed by the start pattern 0,0,1. It measures the bit period from the run-in and decides which format is present: the two-byte caption format or the faster four-byte format. It then samples each payload bit at the centre of its cell. Caption bytes are checked for odd parity. A finished line goes into a register set that software can see, the ready flag is set and the active-low interrupt falls. A pulse on the status-read strobe releases both. Until that read, any later line is dropped so that unread bytes stay as they are.

Top module: `cc_line_extractor`

## Requirements
- R1: After reset, clamp_en is 1, irq_n is 1, data_ready is 0, and data_out, parity_err and fmt_alt are all 0.
- R2: Vertical sync is recognised only when csync_n has been sampled low for more than 48 consecutive clocks (the 49th low sample). A low of 48 clocks or fewer has no effect on the line count or on clamp_en.
- R3: When vertical sync is recognised, the line count restarts at 1 and clamp_en goes to 0. Each rising edge of hsync advances the count by one. clamp_en returns to 1 when the count reaches line 28 and stays at 1 from then on.
- R4: The field is decided at the first hsync rise after csync_n returns high following vertical sync. A rise within 40 clocks means the second field (cfg_field = 1). A later rise means the first field (cfg_field = 0).
- R5: Payload is captured only on the line whose count equals cfg_line, in the field equal to cfg_field. Lines of the other field leave the outputs unchanged.
- R6: The bit period is the spacing between run-in edges. A period under 6 clocks selects the four-byte format (fmt_alt = 1, 4 bytes). Any other period selects the caption format (fmt_alt = 0, 2 bytes).
- R7: A line is accepted only if its run-in has at least 5 rising edges (caption format) or at least 8 (four-byte format). The run-in must then be followed by a low lasting more than 1.5 bit periods (start bits 0,0) and a rising edge (start bit 1). Any other line is discarded.
- R8: Each bit is sampled at the centre of its cell, measured from the start-bit edge, and each byte is received least significant bit first. Byte i appears at data_out[8i+7:8i]. A caption line sets bytes 2 and 3 to 0.
- R9: For caption lines, parity_err[i] is 1 when byte i (all 8 bits) holds an even number of ones. Four-byte lines always leave parity_err at 0.
- R10: When a line is committed, data_ready goes to 1 and irq_n falls to 0. A one-clock pulse on stat_rd returns data_ready to 0 and irq_n to 1 at the next edge.
- R11: While data_ready is 1, further completed lines are discarded and data_out, parity_err and fmt_alt do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Sliced composite sync, low during sync |
| hsync | input | 1 | Horizontal pulse, rising edge starts a line |
| vid_bit | input | 1 | Sliced video data bit |
| cfg_line | input | LINE_W (9) | Line number to extract |
| cfg_field | input | 1 | Field to extract: 0 first, 1 second |
| stat_rd | input | 1 | Status read strobe, clears ready |
| clamp_en | output | 1 | Clamp enable, low from vertical sync to line 28 |
| irq_n | output | 1 | Active-low interrupt, falls when data is ready |
| data_out | output | 8*ALT_BYTES (32) | Captured bytes, byte 0 in the low bits |
| fmt_alt | output | 1 | 1: four-byte format, 0: caption format |
| data_ready | output | 1 | Committed data not yet read |
| parity_err | output | ALT_BYTES (4) | Per-byte parity failure |

## Verification
The extractor is driven with caption lines whose bytes have good parity, one bad byte, or two bad bytes. These show that parity is judged per byte and that bit order and byte placement are right. Four-byte lines at a half-length bit period separate the two formats and show that parity is ignored in the fast format. Lines with too short a run-in, sent in the wrong field, or arriving before the previous line was read must leave the outputs untouched. Sync lows of 48 and 49 clocks, and a run of 27 versus 28 lines, pin down the vertical-sync width limit and the clamp boundary.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
   typedef enum logic [2:0] {
      RX_OFF,
      RX_ARMED,
      RX_RUNIN,
      RX_START,
      RX_DATA
   } rx_state_e;
endpackage

// File: rtl/cc_sync_tracker.sv
`timescale 1ns/1ps
module cc_sync_tracker #(
   parameter int VS_MIN     = 48,
   parameter int LINE_W     = 9,
   parameter int CLAMP_LINE = 28,
   parameter int FIELD_WIN  = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csync_n,
   input  logic              hsync,
   output logic              vs_det,
   output logic              line_start,
   output logic [LINE_W-1:0] line_cnt,
   output logic              field,
   output logic              clamp_en
);
   localparam int LCW = $clog2(VS_MIN + 2);
   localparam logic [LCW-1:0] VS_LIM  = LCW'(VS_MIN);
   localparam logic [LCW-1:0] LOW_SAT = LCW'(VS_MIN + 1);
   localparam int FTW = $clog2(FIELD_WIN + 1);
   localparam logic [FTW-1:0] FT_LIM = FTW'(FIELD_WIN);
   localparam logic [LINE_W-1:0] LINE_MAX = '1;
   localparam logic [LINE_W-1:0] CL_PRE   = LINE_W'(CLAMP_LINE - 1);

   initial begin
      assert (CLAMP_LINE > 1 && CLAMP_LINE < (1 << LINE_W))
         else $error("CLAMP_LINE must fit the line counter");
      assert (VS_MIN > 1) else $error("VS_MIN too small");
   end

   logic           cs_q, hs_q, hs_qq;
   logic [LCW-1:0] low_cnt;
   logic           in_vs, fmeas, blank;
   logic [FTW-1:0] ftimer;
   logic           hs_rise;

   assign hs_rise  = hs_q & ~hs_qq;
   assign vs_det   = ~cs_q && (low_cnt == VS_LIM);
   assign clamp_en = ~blank;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q       <= 1'b1;
         hs_q       <= 1'b0;
         hs_qq      <= 1'b0;
         low_cnt    <= '0;
         in_vs      <= 1'b0;
         fmeas      <= 1'b0;
         ftimer     <= '0;
         field      <= 1'b0;
         line_cnt   <= '0;
         blank      <= 1'b0;
         line_start <= 1'b0;
      end else begin
         cs_q  <= csync_n;
         hs_q  <= hsync;
         hs_qq <= hs_q;
         if (cs_q)
            low_cnt <= '0;
         else if (low_cnt != LOW_SAT)
            low_cnt <= low_cnt + 1'b1;
         if (fmeas && ftimer != FT_LIM)
            ftimer <= ftimer + 1'b1;
         line_start <= hs_rise && !vs_det;
         if (vs_det) begin
            in_vs    <= 1'b1;
            fmeas    <= 1'b0;
            line_cnt <= LINE_W'(1);
            blank    <= 1'b1;
         end else begin
            if (in_vs && cs_q) begin
               in_vs  <= 1'b0;
               fmeas  <= 1'b1;
               ftimer <= '0;
            end
            if (hs_rise) begin
               if (line_cnt != LINE_MAX)
                  line_cnt <= line_cnt + 1'b1;
               if (line_cnt == CL_PRE)
                  blank <= 1'b0;
               if (fmeas) begin
                  field <= (ftimer < FT_LIM);
                  fmeas <= 1'b0;
               end
            end
         end
      end
   end

   p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vs_det |=> (line_cnt == LINE_W'(1) && !clamp_en));
   p_clamp_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clamp_en |-> (line_cnt < LINE_W'(CLAMP_LINE)));
endmodule

// File: rtl/cc_bit_receiver.sv
`timescale 1ns/1ps
module cc_bit_receiver
   import cc_pkg::*;
#(
   parameter int CNT_W         = 10,
   parameter int SPLIT_PERIOD  = 6,
   parameter int CC_RUNIN_MIN  = 5,
   parameter int ALT_RUNIN_MIN = 8,
   parameter int CC_BYTES      = 2,
   parameter int ALT_BYTES     = 4,
   parameter bit ODD_PARITY    = 1'b1,
   localparam int IW = $clog2(ALT_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vid_bit,
   input  logic          vs_det,
   input  logic          line_start,
   input  logic          line_hit,
   output logic          byte_we,
   output logic [IW-1:0] byte_idx,
   output logic [7:0]    byte_val,
   output logic          byte_perr,
   output logic          line_done,
   output logic          done_alt
);
   localparam int RMAX = (ALT_RUNIN_MIN > CC_RUNIN_MIN) ? ALT_RUNIN_MIN : CC_RUNIN_MIN;
   localparam int RW   = $clog2(RMAX + 1);
   localparam logic [RW-1:0]    RISE_SAT = '1;
   localparam logic [RW-1:0]    CC_MIN   = RW'(CC_RUNIN_MIN);
   localparam logic [RW-1:0]    ALT_MIN  = RW'(ALT_RUNIN_MIN);
   localparam logic [CNT_W-1:0] CNT_SAT  = '1;
   localparam logic [CNT_W-1:0] SPLIT_V  = CNT_W'(SPLIT_PERIOD);
   localparam logic [IW-1:0]    CC_LAST  = IW'(CC_BYTES - 1);
   localparam logic [IW-1:0]    ALT_LAST = IW'(ALT_BYTES - 1);

   initial begin
      assert (CC_BYTES > 0 && CC_BYTES < ALT_BYTES)
         else $error("caption byte count must be below the four-byte count");
      assert (SPLIT_PERIOD > 1) else $error("SPLIT_PERIOD too small");
   end

   rx_state_e        state;
   logic             d_q, d_qq, alt;
   logic [CNT_W-1:0] cnt, per, target;
   logic [RW-1:0]    rises;
   logic [2:0]       bitn;
   logic [IW-1:0]    bytn;
   logic [7:0]       sr, nxt_byte;
   logic             edge_seen, rise_seen, par_bad, fast, qualified;
   logic [CNT_W-1:0] per15;
   logic [CNT_W+1:0] per4;

   assign edge_seen = d_q ^ d_qq;
   assign rise_seen = d_q & ~d_qq;
   assign per15     = per + (per >> 1);
   assign per4      = {per, 2'b00};
   assign fast      = (per < SPLIT_V);
   assign qualified = fast ? (rises >= ALT_MIN) : (rises >= CC_MIN);
   assign nxt_byte  = {d_q, sr[7:1]};
   assign done_alt  = alt;

   generate
      if (ODD_PARITY) begin : g_odd
         assign par_bad = ~(^nxt_byte);
      end else begin : g_even
         assign par_bad = ^nxt_byte;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_OFF;
         d_q       <= 1'b0;
         d_qq      <= 1'b0;
         cnt       <= '0;
         per       <= '0;
         target    <= '0;
         rises     <= '0;
         bitn      <= '0;
         bytn      <= '0;
         sr        <= '0;
         alt       <= 1'b0;
         byte_we   <= 1'b0;
         byte_idx  <= '0;
         byte_val  <= '0;
         byte_perr <= 1'b0;
         line_done <= 1'b0;
      end else begin
         d_q       <= vid_bit;
         d_qq      <= d_q;
         byte_we   <= 1'b0;
         line_done <= 1'b0;
         if (cnt != CNT_SAT)
            cnt <= cnt + 1'b1;
         if (vs_det) begin
            state <= RX_OFF;
         end else if (line_start) begin
            state <= line_hit ? RX_ARMED : RX_OFF;
         end else begin
            unique case (state)
               RX_ARMED: if (rise_seen) begin
                  state <= RX_RUNIN;
                  cnt   <= CNT_W'(1);
                  per   <= '0;
                  rises <= RW'(1);
               end
               RX_RUNIN: begin
                  if (edge_seen) begin
                     per <= cnt;
                     cnt <= CNT_W'(1);
                     if (rise_seen && rises != RISE_SAT)
                        rises <= rises + 1'b1;
                  end else if (!d_q && per != '0 && cnt > per15) begin
                     state <= RX_START;
                  end else if (cnt == CNT_SAT) begin
                     state <= RX_OFF;
                  end
               end
               RX_START: begin
                  if (rise_seen) begin
                     if (qualified) begin
                        state  <= RX_DATA;
                        alt    <= fast;
                        cnt    <= CNT_W'(1);
                        target <= per15;
                        bitn   <= '0;
                        bytn   <= '0;
                     end else begin
                        state <= RX_OFF;
                     end
                  end else if ({2'b00, cnt} > per4) begin
                     state <= RX_OFF;
                  end
               end
               RX_DATA: if (cnt == target) begin
                  target <= target + per;
                  sr     <= nxt_byte;
                  bitn   <= bitn + 1'b1;
                  if (bitn == 3'd7) begin
                     byte_we   <= 1'b1;
                     byte_val  <= nxt_byte;
                     byte_idx  <= bytn;
                     byte_perr <= !alt && par_bad;
                     bytn      <= bytn + 1'b1;
                     if (bytn == (alt ? ALT_LAST : CC_LAST)) begin
                        line_done <= 1'b1;
                        state     <= RX_OFF;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   p_done_with_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |-> byte_we);
   p_vs_aborts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vs_det |=> (state == RX_OFF));
   p_alt_no_perr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_we && done_alt) |-> !byte_perr);
endmodule

// File: rtl/cc_result_buffer.sv
`timescale 1ns/1ps
module cc_result_buffer #(
   parameter int NBYTES   = 4,
   parameter int CC_BYTES = 2,
   localparam int IW = $clog2(NBYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_we,
   input  logic [IW-1:0]     byte_idx,
   input  logic [7:0]        byte_val,
   input  logic              byte_perr,
   input  logic              line_done,
   input  logic              done_alt,
   input  logic              stat_rd,
   output logic [NBYTES*8-1:0] data_out,
   output logic [NBYTES-1:0] parity_err,
   output logic              fmt_alt,
   output logic              data_ready
);
   logic commit;
   assign commit = line_done && !data_ready;

   generate
      for (genvar i = 0; i < NBYTES; i++) begin : g_slot
         logic [7:0] sh_byte, vis_byte;
         logic       sh_perr, vis_perr, hit;
         assign hit = byte_we && (byte_idx == IW'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_byte  <= '0;
               sh_perr  <= 1'b0;
               vis_byte <= '0;
               vis_perr <= 1'b0;
            end else begin
               if (hit) begin
                  sh_byte <= byte_val;
                  sh_perr <= byte_perr;
               end
               if (commit) begin
                  if (i < CC_BYTES || done_alt) begin
                     vis_byte <= hit ? byte_val : sh_byte;
                     vis_perr <= hit ? byte_perr : sh_perr;
                  end else begin
                     vis_byte <= '0;
                     vis_perr <= 1'b0;
                  end
               end
            end
         end
         assign data_out[8*i +: 8] = vis_byte;
         assign parity_err[i]      = vis_perr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_ready <= 1'b0;
         fmt_alt    <= 1'b0;
      end else if (commit) begin
         data_ready <= 1'b1;
         fmt_alt    <= done_alt;
      end else if (stat_rd) begin
         data_ready <= 1'b0;
      end
   end

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (data_ready && !stat_rd) |=> ($stable(data_out) && $stable(parity_err) && $stable(fmt_alt)));
   p_rd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !line_done) |=> !data_ready);
   p_alt_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_ready && fmt_alt) |-> (parity_err == '0));
   p_cc_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (data_ready && !fmt_alt) |-> (data_out[NBYTES*8-1:CC_BYTES*8] == '0));
endmodule

// File: rtl/cc_line_extractor.sv
`timescale 1ns/1ps
module cc_line_extractor #(
   parameter int VS_MIN        = 48,
   parameter int LINE_W        = 9,
   parameter int CLAMP_LINE    = 28,
   parameter int FIELD_WIN     = 40,
   parameter int CNT_W         = 10,
   parameter int SPLIT_PERIOD  = 6,
   parameter int CC_RUNIN_MIN  = 5,
   parameter int ALT_RUNIN_MIN = 8,
   parameter int CC_BYTES      = 2,
   parameter int ALT_BYTES     = 4,
   parameter bit ODD_PARITY    = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   csync_n,
   input  logic                   hsync,
   input  logic                   vid_bit,
   input  logic [LINE_W-1:0]      cfg_line,
   input  logic                   cfg_field,
   input  logic                   stat_rd,
   output logic                   clamp_en,
   output logic                   irq_n,
   output logic [ALT_BYTES*8-1:0] data_out,
   output logic                   fmt_alt,
   output logic                   data_ready,
   output logic [ALT_BYTES-1:0]   parity_err
);
   localparam int IW = $clog2(ALT_BYTES);

   logic              vs_det, line_start, field, line_hit;
   logic [LINE_W-1:0] line_cnt;
   logic              byte_we, byte_perr, line_done, done_alt;
   logic [IW-1:0]     byte_idx;
   logic [7:0]        byte_val;

   assign line_hit = (line_cnt == cfg_line) && (field == cfg_field);
   assign irq_n    = ~data_ready;

   cc_sync_tracker #(
      .VS_MIN(VS_MIN), .LINE_W(LINE_W), .CLAMP_LINE(CLAMP_LINE), .FIELD_WIN(FIELD_WIN)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .hsync(hsync),
      .vs_det(vs_det), .line_start(line_start), .line_cnt(line_cnt),
      .field(field), .clamp_en(clamp_en)
   );

   cc_bit_receiver #(
      .CNT_W(CNT_W), .SPLIT_PERIOD(SPLIT_PERIOD), .CC_RUNIN_MIN(CC_RUNIN_MIN),
      .ALT_RUNIN_MIN(ALT_RUNIN_MIN), .CC_BYTES(CC_BYTES), .ALT_BYTES(ALT_BYTES),
      .ODD_PARITY(ODD_PARITY)
   ) u_rx (
      .clk(clk), .rst_n(rst_n), .vid_bit(vid_bit), .vs_det(vs_det),
      .line_start(line_start), .line_hit(line_hit),
      .byte_we(byte_we), .byte_idx(byte_idx), .byte_val(byte_val),
      .byte_perr(byte_perr), .line_done(line_done), .done_alt(done_alt)
   );

   cc_result_buffer #(
      .NBYTES(ALT_BYTES), .CC_BYTES(CC_BYTES)
   ) u_buf (
      .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .byte_idx(byte_idx),
      .byte_val(byte_val), .byte_perr(byte_perr), .line_done(line_done),
      .done_alt(done_alt), .stat_rd(stat_rd), .data_out(data_out),
      .parity_err(parity_err), .fmt_alt(fmt_alt), .data_ready(data_ready)
   );

   p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> $past(line_done));
endmodule

// File: tb/cc_line_extractor_test.sv
`timescale 1ns/1ps
module cc_line_extractor_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csync_n = 1'b1;
   logic        hsync = 1'b0;
   logic        vid_bit = 1'b0;
   logic [8:0]  cfg_line = '0;
   logic        cfg_field = 1'b0;
   logic        stat_rd = 1'b0;
   logic        clamp_en, irq_n, fmt_alt, data_ready;
   logic [31:0] data_out;
   logic [3:0]  parity_err;
   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   cc_line_extractor uut (
      .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .hsync(hsync), .vid_bit(vid_bit),
      .cfg_line(cfg_line), .cfg_field(cfg_field), .stat_rd(stat_rd),
      .clamp_en(clamp_en), .irq_n(irq_n), .data_out(data_out), .fmt_alt(fmt_alt),
      .data_ready(data_ready), .parity_err(parity_err)
   );

   typedef struct packed {
      logic        cfgf;
      logic        sentf;
      logic [7:0]  line;
      logic [3:0]  per;
      logic [3:0]  runin;
      logic [2:0]  nb;
      logic [31:0] bytes;
      logic        rdy;
      logic        alt;
      logic [3:0]  perr;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b0, 1'b0, 8'd5, 4'd8, 4'd7,  3'd2, 32'h0000_8301, 1'b1, 1'b0, 4'b0000},
      '{1'b1, 1'b1, 8'd7, 4'd4, 4'd10, 3'd4, 32'h7856_3412, 1'b1, 1'b1, 4'b0000},
      '{1'b0, 1'b0, 8'd9, 4'd8, 4'd7,  3'd2, 32'h0000_0301, 1'b1, 1'b0, 4'b0010},
      '{1'b1, 1'b0, 8'd5, 4'd8, 4'd7,  3'd2, 32'h0000_8301, 1'b0, 1'b0, 4'b0000},
      '{1'b0, 1'b0, 8'd6, 4'd8, 4'd2,  3'd2, 32'h0000_8301, 1'b0, 1'b0, 4'b0000},
      '{1'b1, 1'b1, 8'd6, 4'd8, 4'd7,  3'd2, 32'h0000_7FFE, 1'b1, 1'b0, 4'b0000},
      '{1'b0, 1'b0, 8'd8, 4'd4, 4'd6,  3'd4, 32'h1122_3344, 1'b0, 1'b1, 4'b0000},
      '{1'b0, 1'b0, 8'd4, 4'd8, 4'd7,  3'd2, 32'h0000_8100, 1'b1, 1'b0, 4'b0011}
   };

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_payload(input int per, input int runin, input int nb, input logic [31:0] bytes);
      for (int p = 0; p < runin; p++) begin
         vid_bit = 1'b1; cyc(per);
         vid_bit = 1'b0; cyc(per);
      end
      vid_bit = 1'b0; cyc(2 * per);
      vid_bit = 1'b1; cyc(per);
      for (int b = 0; b < nb * 8; b++) begin
         vid_bit = bytes[b]; cyc(per);
      end
      vid_bit = 1'b0;
   endtask

   task automatic hline(input bit pay, input int per, input int runin, input int nb, input logic [31:0] bytes);
      hsync = 1'b1; csync_n = 1'b0; cyc(4);
      hsync = 1'b0; csync_n = 1'b1; cyc(20);
      if (pay) send_payload(per, runin, nb, bytes);
      cyc(20);
   endtask

   task automatic vsync(input int width, input int gap);
      csync_n = 1'b0; cyc(width);
      csync_n = 1'b1; cyc(gap);
   endtask

   task automatic run_frame(input logic sentf, input int line, input int per, input int runin,
                            input int nb, input logic [31:0] bytes);
      vsync(60, sentf ? 10 : 100);
      for (int l = 2; l < line; l++) hline(1'b0, 0, 0, 0, '0);
      hline(1'b1, per, runin, nb, bytes);
      cyc(10);
   endtask

   task automatic read_status();
      stat_rd = 1'b1; cyc(1);
      stat_rd = 1'b0; cyc(2);
   endtask

   initial begin
      cyc(5);
      rst_n = 1'b1;
      cyc(2);
      // R1: reset values
      chk("R1 clamp_en", 32'(clamp_en), 32'd1);
      chk("R1 irq_n", 32'(irq_n), 32'd1);
      chk("R1 data_ready", 32'(data_ready), 32'd0);
      chk("R1 data_out", data_out, 32'd0);
      chk("R1 parity_err", 32'(parity_err), 32'd0);

      // R2: 48 low clocks are not vertical sync, 49 are
      vsync(48, 5);
      cyc(3);
      chk("R2 48-clock low ignored", 32'(clamp_en), 32'd1);
      vsync(49, 5);
      chk("R2 49-clock low detected", 32'(clamp_en), 32'd0);

      // R3: clamp off through line 27, back on at line 28
      for (int l = 0; l < 26; l++) hline(1'b0, 0, 0, 0, '0);
      chk("R3 clamp off at line 27", 32'(clamp_en), 32'd0);
      hline(1'b0, 0, 0, 0, '0);
      chk("R3 clamp on at line 28", 32'(clamp_en), 32'd1);
      hline(1'b0, 0, 0, 0, '0);
      chk("R3 clamp stays on", 32'(clamp_en), 32'd1);

      // R4 R5 R6 R7 R8 R9 R10: vector table
      for (int i = 0; i < 8; i++) begin
         vec_t v;
         v = VECS[i];
         cfg_line  = 9'(v.line);
         cfg_field = v.cfgf;
         run_frame(v.sentf, int'(v.line), int'(v.per), int'(v.runin), int'(v.nb), v.bytes);
         chk($sformatf("R5 R7 R4 vec%0d ready", i), 32'(data_ready), 32'(v.rdy));
         chk($sformatf("R10 vec%0d irq_n", i), 32'(irq_n), 32'(!v.rdy));
         if (v.rdy) begin
            chk($sformatf("R8 vec%0d data", i), data_out, v.bytes);
            chk($sformatf("R6 vec%0d format", i), 32'(fmt_alt), 32'(v.alt));
            chk($sformatf("R9 vec%0d parity", i), 32'(parity_err), 32'(v.perr));
         end
         read_status();
         chk($sformatf("R10 vec%0d cleared", i), 32'({data_ready, irq_n}), 32'b01);
      end

      // R11: unread data is held against a later line
      cfg_line = 9'd5; cfg_field = 1'b0;
      run_frame(1'b0, 5, 8, 7, 2, 32'h0000_8301);
      chk("R11 first line ready", 32'(data_ready), 32'd1);
      run_frame(1'b0, 5, 8, 7, 2, 32'h0000_0B07);
      chk("R11 unread data kept", data_out, 32'h0000_8301);
      chk("R11 still ready", 32'(data_ready), 32'd1);
      read_status();
      chk("R10 release after read", 32'(irq_n), 32'd1);
      run_frame(1'b0, 5, 8, 7, 2, 32'h0000_0B07);
      chk("R11 accepted after read", data_out, 32'h0000_0B07);
      chk("R10 irq after new line", 32'(irq_n), 32'd0);
      read_status();

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule